// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between a clock synthesizer's internal sources and its output drivers. It gates a group of CPU clock outputs, a group of PCI clock outputs and one free-running PCI output. Three asynchronous active-low requests control it: halt the CPU group, halt the gated PCI group, and power the part down. Every request is first resynchronized to the free-running PCI source clock. The resulting enable then reaches each output through a latch that is transparent only while that output's source clock is low. An output can therefore start or stop only at a low phase, and every high pulse it drives has full width.

A power-down request parks all outputs low, the free-running one included. One PCI cycle later the sequencer raises a shutdown signal for the oscillator and PLL. When the request is released, the shutdown signal drops at once so the sources can restart. A counter on the reference clock then holds the outputs low and raises a wait flag until a programmable settling interval has elapsed. The same settling interval is applied after reset.

Top module: `clk_stop_pwr_ctrl`

## Requirements
- R1: Each request (cpuStopN, pciStopN, pwrDnN, all asserted at 0) passes through a two-stage synchronizer clocked by pciClkIn. A level that is present before rising edge N of pciClkIn decides the pulse at rising edge N+2 of every output it controls. A request held for exactly one cycle removes exactly one pulse.
- R2: While cpuStopN is low, after the R1 latency, every bit of cpuClkOut stays low. Pulses return with the same latency after the request is released.
- R3: While pciStopN is low, after the R1 latency, every bit of pciClkOut stays low. cpuClkOut and pciFreeOut keep toggling.
- R4: cpuStopN has no effect on pciClkOut or pciFreeOut. Both stop requests may be asserted in any combination and each acts only on its own group.
- R5: When pwrDnN goes low, cpuClkOut, pciClkOut and pciFreeOut all stop at pciClkIn edge N+2. oscPllOff rises one pciClkIn edge later (N+3) and stays high while the request is held. All outputs stay low during that time.
- R6: When pwrDnN returns high, oscPllOff drops without waiting for a clock. The outputs stay low until at least WAIT_CYCLES refClkIn cycles have passed. pwrUpWait is high from the moment the parked state is left until the outputs are enabled again.
- R7: No output ever drives a high pulse shorter than half its source clock period, whatever the timing of the requests.
- R8: After reset, oscPllOff is low, all clock outputs are low and pwrUpWait is high. The outputs are enabled only after at least WAIT_CYCLES refClkIn cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset |
| refClkIn | input | 1 | Reference oscillator clock that times the settling wait |
| cpuClkIn | input | 1 | CPU source clock, phase-aligned with pciClkIn |
| pciClkIn | input | 1 | PCI source clock; also the synchronizer clock |
| cpuStopN | input | 1 | Active-low request to halt the CPU group |
| pciStopN | input | 1 | Active-low request to halt the gated PCI group |
| pwrDnN | input | 1 | Active-low power-down request |
| cpuClkOut | output | CPU_OUTS | Gated CPU clock outputs |
| pciClkOut | output | PCI_OUTS | Gated PCI clock outputs |
| pciFreeOut | output | 1 | PCI output unaffected by the stop requests |
| oscPllOff | output | 1 | Shutdown signal for the oscillator and PLL |
| pwrUpWait | output | 1 | High while the settling interval is counting |

## Verification
The hardest condition to create is a request edge that lands in the middle of a high phase, or just before a source edge. A truncated pulse can appear only there, and a scoreboard aligned to clock edges never produces such timing. The bench therefore runs a separate phase in which the stop requests toggle at offsets that drift through every phase of both source clocks. Meanwhile, free-running monitors measure the width of every high pulse on one CPU output, one gated PCI output and the free-running output. The wake path after power-down is reached by holding the request long enough for the park and shutdown sequence to finish. The release is then timed against the reference clock.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef enum logic [1:0] {
    PM_WAIT = 2'd0,
    PM_RUN  = 2'd1,
    PM_PARK = 2'd2,
    PM_OFF  = 2'd3
  } pmState_t;

  // Strobes from control to the gating datapath
  typedef struct packed {
    logic enCpu;
    logic enPci;
    logic enFree;
  } gateStb_t;

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/csp_wait_timer.sv
module csp_wait_timer #(
  parameter int WAIT_CYCLES = 42955,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic holdReq,
  output logic readyOut
);

  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

  logic          holdS;
  logic [CW-1:0] cnt;
  logic          readyQ;

  csp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_holdSync (
    .clk (refClk),
    .rstN(rstN),
    .d   (holdReq),
    .q   (holdS)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      readyQ <= 1'b0;
    end else if (holdS) begin
      cnt    <= '0;
      readyQ <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      readyQ <= (cnt == LIMIT);
    end
  end

  assign readyOut = readyQ;

  p_cnt_bound_r6: assert property (@(posedge refClk) disable iff (!rstN)
    cnt <= LIMIT);

  p_hold_clears_r6: assert property (@(posedge refClk) disable iff (!rstN)
    holdS |=> !readyQ);

  p_ready_after_count_r6: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(readyQ) |-> $past(cnt) == LIMIT);

endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     pciClk,
  input  logic     rstN,
  input  logic     cpuStopN,
  input  logic     pciStopN,
  input  logic     pwrDnN,
  input  logic     readyIn,
  output gateStb_t stb,
  output logic     oscOff,
  output logic     waitOut,
  output logic     holdReq
);

  logic [2:0] reqS;
  logic       cpuStopS, pciStopS, pwrDnS, readyS;
  logic       pdAct, runOk, holdQ;
  pmState_t   state, stateNxt;

  csp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_reqSync (
    .clk (pciClk),
    .rstN(rstN),
    .d   ({cpuStopN, pciStopN, pwrDnN}),
    .q   (reqS)
  );

  csp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_readySync (
    .clk (pciClk),
    .rstN(rstN),
    .d   (readyIn),
    .q   (readyS)
  );

  assign {cpuStopS, pciStopS, pwrDnS} = reqS;
  assign pdAct = !pwrDnS;

  always_comb begin
    stateNxt = state;
    unique case (state)
      PM_WAIT: begin
        if (pdAct)       stateNxt = PM_OFF;
        else if (readyS) stateNxt = PM_RUN;
      end
      PM_RUN:  if (pdAct) stateNxt = PM_PARK;
      PM_PARK: stateNxt = PM_OFF;
      PM_OFF:  if (!pdAct && !readyS) stateNxt = PM_WAIT;
    endcase
  end

  always_ff @(posedge pciClk or negedge rstN) begin
    if (!rstN) begin
      state <= PM_WAIT;
      holdQ <= 1'b0;
    end else begin
      state <= stateNxt;
      holdQ <= (stateNxt == PM_PARK) || (stateNxt == PM_OFF);
    end
  end

  // A synchronized power-down drops every enable in the same cycle
  assign runOk      = (state == PM_RUN) && !pdAct;
  assign stb.enFree = runOk;
  assign stb.enCpu  = runOk && cpuStopS;
  assign stb.enPci  = runOk && pciStopS;

  // Release of the raw request re-enables the sources without a clock
  assign oscOff  = (state == PM_OFF) && !pwrDnN;
  assign waitOut = (state == PM_WAIT);
  assign holdReq = holdQ;

  p_osc_after_park_r5: assert property (@(posedge pciClk) disable iff (!rstN)
    $rose(state == PM_OFF) |-> $past(!stb.enFree));

  p_park_one_cycle_r5: assert property (@(posedge pciClk) disable iff (!rstN)
    (state == PM_PARK) |=> (state == PM_OFF));

  p_enable_needs_ready_r6: assert property (@(posedge pciClk) disable iff (!rstN)
    $rose(stb.enFree) |-> readyS);

endmodule

// File: rtl/csp_gate.sv
module csp_gate (
  input  logic clkIn,
  input  logic rstN,
  input  logic enIn,
  output logic clkOut
);

  logic enQ;
  logic riseQ;

  // Transparent only during the low phase of the source clock
  always_latch begin
    if (!clkIn) enQ = enIn;
  end

  assign clkOut = clkIn & enQ;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) riseQ <= 1'b0;
    else       riseQ <= enQ;
  end

  p_gate_steady_high_r7: assert property (@(negedge clkIn) disable iff (!rstN)
    enQ == riseQ);

endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int CPU_OUTS = 2,
  parameter int PCI_OUTS = 5
) (
  input  logic                cpuClkIn,
  input  logic                pciClkIn,
  input  logic                rstN,
  input  gateStb_t            stb,
  output logic [CPU_OUTS-1:0] cpuClkOut,
  output logic [PCI_OUTS-1:0] pciClkOut,
  output logic                pciFreeOut
);

  for (genvar i = 0; i < CPU_OUTS; i++) begin : g_cpu
    csp_gate u_gate (
      .clkIn (cpuClkIn),
      .rstN  (rstN),
      .enIn  (stb.enCpu),
      .clkOut(cpuClkOut[i])
    );
  end

  for (genvar j = 0; j < PCI_OUTS; j++) begin : g_pci
    csp_gate u_gate (
      .clkIn (pciClkIn),
      .rstN  (rstN),
      .enIn  (stb.enPci),
      .clkOut(pciClkOut[j])
    );
  end

  csp_gate u_freeGate (
    .clkIn (pciClkIn),
    .rstN  (rstN),
    .enIn  (stb.enFree),
    .clkOut(pciFreeOut)
  );

endmodule

// File: rtl/clk_stop_pwr_ctrl.sv
module clk_stop_pwr_ctrl
  import csp_pkg::*;
#(
  parameter int CPU_OUTS    = 2,
  parameter int PCI_OUTS    = 5,
  parameter int WAIT_CYCLES = 42955,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rstN,
  input  logic                refClkIn,
  input  logic                cpuClkIn,
  input  logic                pciClkIn,
  input  logic                cpuStopN,
  input  logic                pciStopN,
  input  logic                pwrDnN,
  output logic [CPU_OUTS-1:0] cpuClkOut,
  output logic [PCI_OUTS-1:0] pciClkOut,
  output logic                pciFreeOut,
  output logic                oscPllOff,
  output logic                pwrUpWait
);

  gateStb_t stb;
  logic     holdReq;
  logic     ready;

  csp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .pciClk  (pciClkIn),
    .rstN    (rstN),
    .cpuStopN(cpuStopN),
    .pciStopN(pciStopN),
    .pwrDnN  (pwrDnN),
    .readyIn (ready),
    .stb     (stb),
    .oscOff  (oscPllOff),
    .waitOut (pwrUpWait),
    .holdReq (holdReq)
  );

  csp_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .refClk  (refClkIn),
    .rstN    (rstN),
    .holdReq (holdReq),
    .readyOut(ready)
  );

  csp_datapath #(.CPU_OUTS(CPU_OUTS), .PCI_OUTS(PCI_OUTS)) u_dp (
    .cpuClkIn  (cpuClkIn),
    .pciClkIn  (pciClkIn),
    .rstN      (rstN),
    .stb       (stb),
    .cpuClkOut (cpuClkOut),
    .pciClkOut (pciClkOut),
    .pciFreeOut(pciFreeOut)
  );

  p_parked_while_off_r5: assert property (@(negedge pciClkIn) disable iff (!rstN)
    oscPllOff |-> (!pciFreeOut && (pciClkOut == '0)));

endmodule

// File: tb/sim_clk_stop_pwr_ctrl.sv
module sim_clk_stop_pwr_ctrl;

  localparam int CLK_PERIOD = 60;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int QUART      = CLK_PERIOD / 4;
  localparam int REF_PERIOD = 70;
  localparam int WAIT_CYC   = 24;
  localparam int NCPU       = 2;
  localparam int NPCI       = 5;

  logic rstN = 1'b0, refClk = 1'b0, cpuClk = 1'b0, pciClk = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1, pwrDnN = 1'b1;
  logic [NCPU-1:0] cpuOut;
  logic [NPCI-1:0] pciOut;
  logic freeOut, oscOff, waitFlag;

  int nChecks = 0, nFails = 0;
  int refCnt = 0, freePulses = 0, glitchCnt = 0, pulseCnt = 0;
  time tRiseP = 0, tRiseC = 0, tRiseF = 0;

  clk_stop_pwr_ctrl #(
    .CPU_OUTS(NCPU), .PCI_OUTS(NPCI), .WAIT_CYCLES(WAIT_CYC), .SYNC_STAGES(2)
  ) u0 (
    .rstN(rstN), .refClkIn(refClk), .cpuClkIn(cpuClk), .pciClkIn(pciClk),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .pwrDnN(pwrDnN),
    .cpuClkOut(cpuOut), .pciClkOut(pciOut), .pciFreeOut(freeOut),
    .oscPllOff(oscOff), .pwrUpWait(waitFlag)
  );

  // CPU source at twice the PCI rate, rising edges aligned
  initial forever begin
    pciClk = 1'b1; cpuClk = 1'b1;
    #QUART cpuClk = 1'b0;
    #QUART pciClk = 1'b0; cpuClk = 1'b1;
    #QUART cpuClk = 1'b0;
    #QUART;
  end

  initial forever #(REF_PERIOD/2) refClk = ~refClk;

  always @(posedge refClk) refCnt++;
  always @(posedge freeOut) freePulses++;

  // Pulse-width monitors (R7)
  always @(posedge pciOut[0]) tRiseP = $time;
  always @(posedge cpuOut[0]) tRiseC = $time;
  always @(posedge freeOut)   tRiseF = $time;
  always @(negedge pciOut[0]) if (rstN) begin
    pulseCnt++; if ($time - tRiseP != HALF) glitchCnt++;
  end
  always @(negedge cpuOut[0]) if (rstN) begin
    pulseCnt++; if ($time - tRiseC != QUART) glitchCnt++;
  end
  always @(negedge freeOut) if (rstN) begin
    pulseCnt++; if ($time - tRiseF != HALF) glitchCnt++;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    logic [NCPU-1:0] cpu;
    logic [NPCI-1:0] pci;
    logic            free;
    logic            osc;
    string           tag;
  } expItem_t;

  typedef struct packed { logic c; logic p; logic d; } req_t;

  expItem_t sbQ[$];
  req_t h1, h2, h3;

  // Monitor: one expected item per PCI rising edge, sampled mid-high
  initial forever begin
    expItem_t e;
    @(posedge pciClk);
    #10;
    if (sbQ.size() > 0) begin
      e = sbQ.pop_front();
      check(e.tag, "cpuClkOut",  32'(cpuOut),  32'(e.cpu));
      check(e.tag, "pciClkOut",  32'(pciOut),  32'(e.pci));
      check(e.tag, "pciFreeOut", 32'(freeOut), 32'(e.free));
      check(e.tag, "oscPllOff",  32'(oscOff),  32'(e.osc));
      check(e.tag, "pwrUpWait",  32'(waitFlag), 32'd0);
    end
  end

  // Driver: apply requests in the low phase, predict the next edge
  task automatic drive(input bit c, input bit p, input bit d, input string tag);
    req_t cur, gov;
    expItem_t e;
    @(negedge pciClk);
    #5;
    cur.c = c; cur.p = p; cur.d = d;
    cpuStopN = !c; pciStopN = !p; pwrDnN = !d;
    gov    = h2;
    e.cpu  = (!gov.d && !gov.c) ? '1 : '0;
    e.pci  = (!gov.d && !gov.p) ? '1 : '0;
    e.free = !gov.d;
    e.osc  = cur.d && h1.d && h2.d && h3.d;
    e.tag  = tag;
    sbQ.push_back(e);
    h3 = h2; h2 = h1; h1 = cur;
  endtask

  task automatic clearHist();
    h1 = '0; h2 = '0; h3 = '0;
  endtask

  task automatic drain();
    wait (sbQ.size() == 0);
    @(posedge pciClk);
    #15;
  endtask

  task automatic waitLevel(input logic lvl, input string tag);
    int n;
    n = 0;
    while (waitFlag !== lvl && n < 2000) begin
      @(posedge pciClk); #10; n++;
    end
    check(tag, "pwrUpWait level reached", 32'(waitFlag), 32'(lvl));
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int t0, waited;
    clearHist();
    repeat (3) @(posedge pciClk);
    @(negedge pciClk); #5;
    rstN = 1'b1;
    t0 = refCnt;

    // R8: reset state, sampled in a high phase of the sources
    @(posedge pciClk); #10;
    check("R8", "pwrUpWait after reset", 32'(waitFlag), 32'd1);
    check("R8", "oscPllOff after reset", 32'(oscOff),   32'd0);
    check("R8", "cpuClkOut after reset", 32'(cpuOut),   32'd0);
    check("R8", "pciClkOut after reset", 32'(pciOut),   32'd0);
    check("R8", "pciFreeOut after reset", 32'(freeOut), 32'd0);
    waitLevel(1'b0, "R8");
    waited = refCnt - t0;
    check("R8", "settle lower bound", 32'(waited >= WAIT_CYC), 32'd1);
    check("R8", "settle upper bound", 32'(waited <= WAIT_CYC + 12), 32'd1);

    // R1..R4: stop requests
    repeat (3) drive(0, 0, 0, "R1");
    repeat (4) drive(1, 0, 0, "R2");
    repeat (3) drive(0, 0, 0, "R2");
    repeat (4) drive(0, 1, 0, "R3");
    repeat (3) drive(0, 0, 0, "R3");
    repeat (3) drive(1, 1, 0, "R4");
    drive(0, 1, 0, "R4");
    drive(1, 0, 0, "R4");
    repeat (3) drive(0, 0, 0, "R4");
    drive(1, 0, 0, "R1");
    repeat (3) drive(0, 0, 0, "R1");
    drive(0, 1, 0, "R1");
    repeat (3) drive(0, 0, 0, "R1");
    drain();

    // R5: power-down entry, then R6: release and settle
    repeat (6) drive(0, 0, 1, "R5");
    drive(0, 0, 0, "R6");
    t0 = refCnt;
    freePulses = 0;
    drain();
    waitLevel(1'b1, "R6");
    check("R6", "oscPllOff after release", 32'(oscOff), 32'd0);
    waitLevel(1'b0, "R6");
    waited = refCnt - t0;
    check("R6", "settle lower bound", 32'(waited >= WAIT_CYC), 32'd1);
    check("R6", "no pulses while settling", 32'(freePulses), 32'd0);
    clearHist();
    repeat (4) drive(0, 0, 0, "R6");
    drain();

    // R7: requests toggled at drifting offsets
    pulseCnt = 0;
    for (int i = 0; i < 40; i++) begin
      #(7 + (i * 23) % 53);
      case (i % 3)
        0: cpuStopN = ~cpuStopN;
        1: pciStopN = ~pciStopN;
        default: begin cpuStopN = ~cpuStopN; pciStopN = ~pciStopN; end
      endcase
    end
    cpuStopN = 1'b1; pciStopN = 1'b1;
    repeat (6) @(posedge pciClk);
    #10;
    check("R7", "short pulses seen", 32'(glitchCnt), 32'd0);
    check("R7", "pulses observed", 32'(pulseCnt > 20), 32'd1);
    check("R3", "pci group restarted", 32'(pciOut), {27'd0, {NPCI{1'b1}}});
    finish();
  end

endmodule